// File: doc/BRIEF.md
# Fused Multiply-Add Special-Case Resolver

This block sits at the front of a double-precision fused multiply-add unit that computes z + x*y. It takes the three raw 64-bit operands and sorts each one into a class. From the classes and signs it decides whether the result is already fixed by the IEEE 754 special-value rules: NaN propagation, invalid products, infinities, or a zero product. When the result is fixed, it raises a bypass flag and supplies the final 64-bit encoding, together with an invalid-operation flag.

When the arithmetic datapath has to compute the result, the bypass flag stays low. The block then tells the datapath which multiplicands are subnormal and need pre-normalisation.

NaN handling follows a fixed order of precedence:
- A signalling-NaN addend comes first.
- A signalling NaN in x comes next, then a signalling NaN in y.
- A quiet NaN in x follows, then a quiet NaN in y.
- A quiet-NaN addend only wins once no multiplicand is a NaN.

All outputs are registered once, so the results appear one clock after the operands.

Top module: `fma_special_resolve`

## Requirements
- R1: Each operand is reported as a 3-bit class code: 0 zero, 1 normal, 2 subnormal, 3 infinity, 4 quiet NaN, 5 signalling NaN. An all-ones exponent with a nonzero fraction is a NaN. Fraction bit 51 set means quiet and clear means signalling. An all-zero exponent with a nonzero fraction is subnormal.
- R2: When z is a signalling NaN, the block asserts bypass and invalid and returns z with fraction bit 51 set, whatever x and y are.
- R3: When x is a signalling NaN (and z is not), the result is x made quiet. When y is a signalling NaN and x is not, the result is y made quiet, even if x is a quiet NaN. Both cases raise invalid.
- R4: When no operand is signalling, a quiet NaN in x is returned unchanged; failing that, a quiet NaN in y is returned unchanged. Neither case raises invalid.
- R5: For infinity times zero in either order, a quiet-NaN z is returned with invalid low. Otherwise invalid is raised and the default NaN 0x7FF8000000000000 is returned.
- R6: For infinity times a nonzero non-NaN value, a quiet-NaN z is returned unchanged. If z is an infinity of the opposite sign to the product, invalid is raised and the default NaN is returned. Otherwise the result is an infinity (exponent all ones, fraction zero) with sign x_sign XOR y_sign.
- R7: For a zero product from non-NaN, non-infinite multiplicands, an infinite z gives an infinity with z's sign. Otherwise z is returned unchanged, including a quiet-NaN z.
- R8: With two finite nonzero multiplicands, a quiet-NaN z is returned and an infinite z gives an infinity with z's sign. Otherwise bypass is low, the result bus is zero and invalid is low.
- R9: Whenever bypass is high, both normalisation requests are low. When the datapath is selected, norm_x is high exactly when x is subnormal and norm_y exactly when y is subnormal.
- R10: Invalid is high only together with bypass, and only in the cases named in R2, R3, R5 and R6.
- R11: Every output changes one clock after its operands are sampled. While reset is asserted, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_x | input | 64 | First multiplicand, raw encoding |
| op_y | input | 64 | Second multiplicand, raw encoding |
| op_z | input | 64 | Addend, raw encoding |
| bypass | output | 1 | Result is fixed by a special case |
| invalid | output | 1 | Invalid-operation exception |
| result | output | 64 | Bypass result encoding, zero when not bypassing |
| norm_x | output | 1 | Datapath must pre-normalise subnormal x |
| norm_y | output | 1 | Datapath must pre-normalise subnormal y |
| cls_x | output | 3 | Class code of x |
| cls_y | output | 3 | Class code of y |
| cls_z | output | 3 | Class code of z |

## Verification
The vector table pairs NaNs of both kinds across all three operand positions, so that each step of the precedence chain is separated from its neighbour. It covers a signalling y against a quiet x, a signalling x against a signalling y, and a quiet-NaN z losing to a multiplicand NaN. Infinite products meet zero, same-sign and opposite-sign infinite addends and a quiet-NaN addend, which separates R5 from R6. Zero products and finite products are tried against infinite, NaN and ordinary addends, and subnormal operands in every position show the normalisation requests appearing only on the datapath path. Directed checks cover the class codes, the reset value and the one-cycle latency.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

    localparam int unsigned FSR_DATA_W = 64;
    localparam int unsigned FSR_EXP_W  = 11;

    typedef enum logic [2:0] {
        CLS_ZERO = 3'd0,
        CLS_NORM = 3'd1,
        CLS_SUB  = 3'd2,
        CLS_INF  = 3'd3,
        CLS_QNAN = 3'd4,
        CLS_SNAN = 3'd5
    } fsr_cls_e;

endpackage

// File: rtl/fsr_classify.sv
module fsr_classify
    import fsr_pkg::*;
#(
    parameter int unsigned DATA_W = FSR_DATA_W,
    parameter int unsigned EXP_W  = FSR_EXP_W
) (
    input  logic [DATA_W-1:0] op_i,
    output fsr_cls_e          cls_o,
    output logic              sign_o
);
    localparam int unsigned FRAC_W = DATA_W - EXP_W - 1;

    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;
    logic              exp_ones;
    logic              exp_zero;
    logic              frac_zero;

    always_comb begin
        exp_f     = op_i[DATA_W-2 -: EXP_W];
        frac_f    = op_i[FRAC_W-1:0];
        exp_ones  = &exp_f;
        exp_zero  = ~|exp_f;
        frac_zero = ~|frac_f;
        sign_o    = op_i[DATA_W-1];

        if (exp_ones) begin
            if (frac_zero)              cls_o = CLS_INF;
            else if (frac_f[FRAC_W-1])  cls_o = CLS_QNAN;
            else                        cls_o = CLS_SNAN;
        end else if (exp_zero) begin
            cls_o = frac_zero ? CLS_ZERO : CLS_SUB;
        end else begin
            cls_o = CLS_NORM;
        end
    end

endmodule

// File: rtl/fsr_nan_pick.sv
module fsr_nan_pick
    import fsr_pkg::*;
#(
    parameter int unsigned DATA_W = FSR_DATA_W,
    parameter int unsigned EXP_W  = FSR_EXP_W
) (
    input  logic [DATA_W-1:0] x_i,
    input  logic [DATA_W-1:0] y_i,
    input  logic [DATA_W-1:0] z_i,
    input  fsr_cls_e          cx_i,
    input  fsr_cls_e          cy_i,
    input  fsr_cls_e          cz_i,
    output logic              hit_o,
    output logic              inv_o,
    output logic [DATA_W-1:0] res_o
);
    localparam int unsigned FRAC_W = DATA_W - EXP_W - 1;
    localparam logic [DATA_W-1:0] QUIET_BIT = DATA_W'(1) << (FRAC_W - 1);

    // Fixed precedence: addend signalling, x signalling, y signalling,
    // x quiet, y quiet. A quiet-NaN addend is left to the product logic.
    always_comb begin
        hit_o = 1'b1;
        inv_o = 1'b0;
        res_o = '0;
        if (cz_i == CLS_SNAN) begin
            inv_o = 1'b1;
            res_o = z_i | QUIET_BIT;
        end else if (cx_i == CLS_SNAN) begin
            inv_o = 1'b1;
            res_o = x_i | QUIET_BIT;
        end else if (cy_i == CLS_SNAN) begin
            inv_o = 1'b1;
            res_o = y_i | QUIET_BIT;
        end else if (cx_i == CLS_QNAN) begin
            res_o = x_i;
        end else if (cy_i == CLS_QNAN) begin
            res_o = y_i;
        end else begin
            hit_o = 1'b0;
        end
    end

endmodule

// File: rtl/fsr_special.sv
module fsr_special
    import fsr_pkg::*;
#(
    parameter int unsigned DATA_W = FSR_DATA_W,
    parameter int unsigned EXP_W  = FSR_EXP_W
) (
    input  logic [DATA_W-1:0] z_i,
    input  fsr_cls_e          cx_i,
    input  fsr_cls_e          cy_i,
    input  fsr_cls_e          cz_i,
    input  logic              sx_i,
    input  logic              sy_i,
    input  logic              sz_i,
    output logic              hit_o,
    output logic              inv_o,
    output logic [DATA_W-1:0] res_o,
    output logic              nx_o,
    output logic              ny_o
);
    localparam int unsigned FRAC_W = DATA_W - EXP_W - 1;
    localparam logic [DATA_W-1:0] DEF_NAN =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    function automatic logic [DATA_W-1:0] make_inf(input logic s);
        return {s, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    endfunction

    logic prod_inf;
    logic prod_zero;
    logic prod_sign;
    logic z_quiet;
    logic z_inf;

    // Only meaningful when neither multiplicand is a NaN and z is not
    // signalling; the top gives the NaN picker precedence.
    always_comb begin
        prod_inf  = (cx_i == CLS_INF)  || (cy_i == CLS_INF);
        prod_zero = (cx_i == CLS_ZERO) || (cy_i == CLS_ZERO);
        prod_sign = sx_i ^ sy_i;
        z_quiet   = (cz_i == CLS_QNAN);
        z_inf     = (cz_i == CLS_INF);

        hit_o = 1'b1;
        inv_o = 1'b0;
        res_o = '0;
        nx_o  = 1'b0;
        ny_o  = 1'b0;

        if (prod_inf && prod_zero) begin
            if (z_quiet) begin
                res_o = z_i;
            end else begin
                inv_o = 1'b1;
                res_o = DEF_NAN;
            end
        end else if (prod_inf) begin
            if (z_quiet) begin
                res_o = z_i;
            end else if (z_inf && (sz_i != prod_sign)) begin
                inv_o = 1'b1;
                res_o = DEF_NAN;
            end else begin
                res_o = make_inf(prod_sign);
            end
        end else if (prod_zero) begin
            res_o = z_inf ? make_inf(sz_i) : z_i;
        end else if (z_quiet) begin
            res_o = z_i;
        end else if (z_inf) begin
            res_o = make_inf(sz_i);
        end else begin
            hit_o = 1'b0;
            nx_o  = (cx_i == CLS_SUB);
            ny_o  = (cy_i == CLS_SUB);
        end
    end

endmodule

// File: rtl/fma_special_resolve.sv
module fma_special_resolve
    import fsr_pkg::*;
#(
    parameter int unsigned DATA_W = FSR_DATA_W,
    parameter int unsigned EXP_W  = FSR_EXP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] op_x,
    input  logic [DATA_W-1:0] op_y,
    input  logic [DATA_W-1:0] op_z,
    output logic              bypass,
    output logic              invalid,
    output logic [DATA_W-1:0] result,
    output logic              norm_x,
    output logic              norm_y,
    output logic [2:0]        cls_x,
    output logic [2:0]        cls_y,
    output logic [2:0]        cls_z
);
    localparam int unsigned NOPS = 3;
    localparam int unsigned IX = 0;
    localparam int unsigned IY = 1;
    localparam int unsigned IZ = 2;

    typedef struct packed {
        logic              byp;
        logic              inv;
        logic              nx;
        logic              ny;
        logic [DATA_W-1:0] res;
        fsr_cls_e          cx;
        fsr_cls_e          cy;
        fsr_cls_e          cz;
    } fsr_state_t;

    logic [NOPS-1:0][DATA_W-1:0] ops;
    fsr_cls_e                    cls  [NOPS];
    logic [NOPS-1:0]             sgn;

    assign ops = {op_z, op_y, op_x};

    for (genvar gi = 0; gi < NOPS; gi++) begin : g_cls
        fsr_classify #(
            .DATA_W (DATA_W),
            .EXP_W  (EXP_W)
        ) u_cls (
            .op_i   (ops[gi]),
            .cls_o  (cls[gi]),
            .sign_o (sgn[gi])
        );
    end

    logic              nan_hit;
    logic              nan_inv;
    logic [DATA_W-1:0] nan_res;

    fsr_nan_pick #(
        .DATA_W (DATA_W),
        .EXP_W  (EXP_W)
    ) u_nan (
        .x_i   (op_x),
        .y_i   (op_y),
        .z_i   (op_z),
        .cx_i  (cls[IX]),
        .cy_i  (cls[IY]),
        .cz_i  (cls[IZ]),
        .hit_o (nan_hit),
        .inv_o (nan_inv),
        .res_o (nan_res)
    );

    logic              sp_hit;
    logic              sp_inv;
    logic [DATA_W-1:0] sp_res;
    logic              sp_nx;
    logic              sp_ny;

    fsr_special #(
        .DATA_W (DATA_W),
        .EXP_W  (EXP_W)
    ) u_spc (
        .z_i   (op_z),
        .cx_i  (cls[IX]),
        .cy_i  (cls[IY]),
        .cz_i  (cls[IZ]),
        .sx_i  (sgn[IX]),
        .sy_i  (sgn[IY]),
        .sz_i  (sgn[IZ]),
        .hit_o (sp_hit),
        .inv_o (sp_inv),
        .res_o (sp_res),
        .nx_o  (sp_nx),
        .ny_o  (sp_ny)
    );

    fsr_state_t st_d;
    fsr_state_t st_q;

    always_comb begin
        st_d.cx = cls[IX];
        st_d.cy = cls[IY];
        st_d.cz = cls[IZ];
        if (nan_hit) begin
            st_d.byp = 1'b1;
            st_d.inv = nan_inv;
            st_d.res = nan_res;
            st_d.nx  = 1'b0;
            st_d.ny  = 1'b0;
        end else begin
            st_d.byp = sp_hit;
            st_d.inv = sp_inv;
            st_d.res = sp_res;
            st_d.nx  = sp_nx;
            st_d.ny  = sp_ny;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{byp: 1'b0, inv: 1'b0, nx: 1'b0, ny: 1'b0, res: '0,
                      cx: CLS_ZERO, cy: CLS_ZERO, cz: CLS_ZERO};
        end else begin
            st_q <= st_d;
        end
    end

    assign bypass  = st_q.byp;
    assign invalid = st_q.inv;
    assign result  = st_q.res;
    assign norm_x  = st_q.nx;
    assign norm_y  = st_q.ny;
    assign cls_x   = st_q.cx;
    assign cls_y   = st_q.cy;
    assign cls_z   = st_q.cz;

endmodule

// File: rtl/fsr_checker.sv
module fsr_checker #(
    parameter int unsigned DATA_W = 64,
    parameter int unsigned EXP_W  = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] op_x,
    input logic [DATA_W-1:0] op_y,
    input logic [DATA_W-1:0] op_z,
    input logic              bypass,
    input logic              invalid,
    input logic [DATA_W-1:0] result,
    input logic              norm_x,
    input logic              norm_y,
    input logic [2:0]        cls_x,
    input logic [2:0]        cls_y,
    input logic [2:0]        cls_z
);
    localparam int unsigned FRAC_W = DATA_W - EXP_W - 1;
    localparam logic [DATA_W-1:0] QBIT = DATA_W'(1) << (FRAC_W - 1);

    logic              armed;
    logic [DATA_W-1:0] z_prev;
    logic              x_nan_prev;
    logic              y_nan_prev;
    logic              z_snan_prev;

    always_ff @(posedge clk) begin
        armed       <= rst_n;
        z_prev      <= op_z;
        x_nan_prev  <= (&op_x[DATA_W-2 -: EXP_W]) && (|op_x[FRAC_W-1:0]);
        y_nan_prev  <= (&op_y[DATA_W-2 -: EXP_W]) && (|op_y[FRAC_W-1:0]);
        z_snan_prev <= (&op_z[DATA_W-2 -: EXP_W]) && (|op_z[FRAC_W-1:0])
                       && !op_z[FRAC_W-1];
    end

    assert_cls_range_R1: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        (cls_x <= 3'd5) && (cls_y <= 3'd5) && (cls_z <= 3'd5));

    assert_zsnan_wins_R2: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        z_snan_prev |-> (bypass && invalid && result == (z_prev | QBIT)));

    assert_nan_mult_bypass_R4: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        (x_nan_prev || y_nan_prev) |-> (bypass && !norm_x && !norm_y));

    assert_no_result_idle_R8: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        !bypass |-> (result == '0 && !invalid));

    assert_norm_off_bypass_R9: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        (norm_x || norm_y) |-> !bypass);

    assert_norm_x_sub_R9: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        norm_x |-> (cls_x == 3'd2));

    assert_norm_y_sub_R9: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        norm_y |-> (cls_y == 3'd2));

    assert_inv_with_bypass_R10: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        invalid |-> bypass);

    assert_cls_latency_R11: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        (z_prev[DATA_W-2:0] == '0) |-> (cls_z == 3'd0));

endmodule

bind fma_special_resolve fsr_checker #(
    .DATA_W (DATA_W),
    .EXP_W  (EXP_W)
) u_fsr_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .op_x    (op_x),
    .op_y    (op_y),
    .op_z    (op_z),
    .bypass  (bypass),
    .invalid (invalid),
    .result  (result),
    .norm_x  (norm_x),
    .norm_y  (norm_y),
    .cls_x   (cls_x),
    .cls_y   (cls_y),
    .cls_z   (cls_z)
);

// File: tb/test_fma_special_resolve.sv
`timescale 1ns/1ps
module test_fma_special_resolve;

    localparam logic [63:0] PZ   = 64'h0000_0000_0000_0000;
    localparam logic [63:0] NZ   = 64'h8000_0000_0000_0000;
    localparam logic [63:0] ONE  = 64'h3FF0_0000_0000_0000;
    localparam logic [63:0] TWO  = 64'h4000_0000_0000_0000;
    localparam logic [63:0] NONE = 64'hBFF0_0000_0000_0000;
    localparam logic [63:0] PINF = 64'h7FF0_0000_0000_0000;
    localparam logic [63:0] NINF = 64'hFFF0_0000_0000_0000;
    localparam logic [63:0] DN   = 64'h7FF8_0000_0000_0000;
    localparam logic [63:0] SUB  = 64'h0000_0000_0000_0001;
    localparam logic [63:0] NSUB = 64'h8000_0000_0000_0003;
    localparam logic [63:0] QZ   = 64'h7FF8_0000_0000_00AB;
    localparam logic [63:0] QX   = 64'hFFF8_0000_0000_0011;
    localparam logic [63:0] QY   = 64'h7FF8_0000_0000_0022;
    localparam logic [63:0] SZ   = 64'h7FF0_0000_0000_000C;
    localparam logic [63:0] SX   = 64'hFFF0_0000_0000_0005;
    localparam logic [63:0] SX2  = 64'h7FF0_0000_0000_0003;
    localparam logic [63:0] SY   = 64'h7FF0_0000_0000_0007;

    // {req, {byp,inv,nx,ny}, x, y, z, expected result}
    localparam int NV = 22;
    localparam logic [267:0] VEC [NV] = '{
        {8'd2,  4'b1100, ONE,  ONE,  SZ,   64'h7FF8_0000_0000_000C}, // R2
        {8'd3,  4'b1100, SX,   QY,   ONE,  64'hFFF8_0000_0000_0005}, // R3 x sNaN
        {8'd3,  4'b1100, QX,   SY,   ONE,  64'h7FF8_0000_0000_0007}, // R3 y sNaN over x qNaN
        {8'd3,  4'b1100, SX2,  SY,   QZ,   64'h7FF8_0000_0000_0003}, // R3 both signalling
        {8'd4,  4'b1000, ONE,  QY,   PINF, QY},                      // R4 y quiet
        {8'd4,  4'b1000, QX,   QY,   QZ,   QX},                      // R4 x quiet first
        {8'd5,  4'b1100, PINF, PZ,   ONE,  DN},                      // R5
        {8'd5,  4'b1000, NZ,   NINF, QZ,   QZ},                      // R5 quiet z
        {8'd6,  4'b1000, PINF, NONE, ONE,  NINF},                    // R6
        {8'd6,  4'b1000, NINF, NONE, PINF, PINF},                    // R6 same-sign z
        {8'd6,  4'b1100, PINF, TWO,  NINF, DN},                      // R6 opposite z
        {8'd6,  4'b1000, PINF, SUB,  QZ,   QZ},                      // R6 quiet z
        {8'd6,  4'b1000, PINF, NINF, ONE,  NINF},                    // R6 inf*inf
        {8'd7,  4'b1000, PZ,   ONE,  NINF, NINF},                    // R7
        {8'd7,  4'b1000, SUB,  NZ,   TWO,  TWO},                     // R7
        {8'd7,  4'b1000, PZ,   PZ,   QZ,   QZ},                      // R7
        {8'd8,  4'b1000, ONE,  TWO,  QZ,   QZ},                      // R8
        {8'd8,  4'b1000, ONE,  SUB,  NINF, NINF},                    // R8
        {8'd8,  4'b0000, ONE,  TWO,  ONE,  PZ},                      // R8 datapath
        {8'd9,  4'b0010, SUB,  ONE,  ONE,  PZ},                      // R9
        {8'd9,  4'b0011, SUB,  NSUB, PZ,   PZ},                      // R9
        {8'd9,  4'b0001, ONE,  SUB,  SUB,  PZ}                       // R9
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] op_x = '0;
    logic [63:0] op_y = '0;
    logic [63:0] op_z = '0;
    logic        bypass, invalid, norm_x, norm_y;
    logic [63:0] result;
    logic [2:0]  cls_x, cls_y, cls_z;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    fma_special_resolve i_fma_special_resolve (
        .clk     (clk),
        .rst_n   (rst_n),
        .op_x    (op_x),
        .op_y    (op_y),
        .op_z    (op_z),
        .bypass  (bypass),
        .invalid (invalid),
        .result  (result),
        .norm_x  (norm_x),
        .norm_y  (norm_y),
        .cls_x   (cls_x),
        .cls_y   (cls_y),
        .cls_z   (cls_z)
    );

    task automatic check_out(input int req, input logic [3:0] ef, input logic [63:0] er);
        logic [3:0] af;
        af = {bypass, invalid, norm_x, norm_y};
        checks++;
        if (af !== ef || result !== er) begin
            failures++;
            $display("FAIL R%0d flags=%b result=%h expected flags=%b result=%h",
                     req, af, result, ef, er);
        end
    endtask

    task automatic check_cls(input logic [8:0] exp_c);
        checks++;
        if ({cls_x, cls_y, cls_z} !== exp_c) begin
            failures++;
            $display("FAIL R1 classes=%h expected=%h", {cls_x, cls_y, cls_z}, exp_c);
        end
    endtask

    task automatic apply(input logic [63:0] x, input logic [63:0] y, input logic [63:0] z);
        @(negedge clk);
        op_x = x;
        op_y = y;
        op_z = z;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R11 reset: outputs zero while reset held with live operands
        op_x = SX; op_y = QY; op_z = PINF;
        repeat (3) @(posedge clk);
        #1;
        check_out(11, 4'b0000, PZ);
        check_cls(9'b000_000_000);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][255:192], VEC[i][191:128], VEC[i][127:64]);
            check_out(int'(VEC[i][267:260]), VEC[i][259:256], VEC[i][63:0]);
        end

        // R1 class codes: x sNaN=5, y qNaN=4, z subnormal=2
        apply(SX, QY, SUB);
        check_cls({3'd5, 3'd4, 3'd2});
        // R1 class codes: x inf=3, y zero=0, z normal=1
        apply(PINF, NZ, ONE);
        check_cls({3'd3, 3'd0, 3'd1});

        // R11 latency: new operands do not show before the next edge
        apply(ONE, TWO, ONE);
        @(negedge clk);
        op_x = PINF; op_y = PZ; op_z = ONE;
        #1;
        check_out(11, 4'b0000, PZ);
        @(posedge clk);
        #1;
        check_out(11, 4'b1100, DN);
        // R10: a plain finite case after an invalid one clears invalid
        apply(TWO, TWO, NONE);
        check_out(10, 4'b0000, PZ);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule